// File: doc/BRIEF.md
# Dual Address Field Microsequencer

This block generates the next control-memory address for a microprogrammed control unit. Every microinstruction carries two explicit next-address fields, A and B, next to its control bits. A small branch unit reads a branch-control code and a flag selector from the current word, together with four live status flags. From these it picks one of three sources: field A, field B, or a routine start address derived from the instruction opcode. The chosen address is loaded into the control address register (CAR) on the next rising clock edge. No incrementer exists, so every step names its successor explicitly.

Address selection is purely combinational from the CAR, the flags and the opcode, so one microinstruction completes per clock. The control store is a constant array built from a fixed formula. The block presents the control-signal field of the addressed word and the CAR value. Instruction decode and the datapath sit outside this block.

Top module: `dual_addr_useq`

## Requirements
- R1: While `rst_ni` is low, the CAR is 0 without waiting for a clock edge, and `ctrl_o` shows the word at address 0, which is `8'h80`.
- R2: Control-store word at address n (6-bit): control field = `8'h80 | n`; field A = (n+3) mod 64; field B = (5n+3) mod 64; branch code = (n[2:0] + n[5:3]) mod 8; flag selector = n[5:4]. `ctrl_o` always equals the control field of the word addressed by `car_o`.
- R3: Branch code 0 loads field A, whatever the flags and opcode are.
- R4: Branch code 1 loads field B, whatever the flags and opcode are.
- R5: Branch code 2 loads field A when the selected flag is 1 and field B when it is 0. The flag selector value chooses a bit of `flags_i`: 0 picks zero (bit 0), 1 picks carry (bit 1), 2 picks negative (bit 2), 3 picks overflow (bit 3).
- R6: Branch code 3 loads `opcode_i` shifted left by 2 (opcode k goes to address 4k).
- R7: Branch codes 4 to 7 are reserved and act as code 0: field A is loaded, and flags and opcode have no effect.
- R8: The CAR changes only on a rising clock edge after reset is released. The flags and opcode present during a cycle decide the address loaded at the end of that cycle, so there is one microinstruction per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 4 | Status flags: bit 0 zero, bit 1 carry, bit 2 negative, bit 3 overflow |
| opcode_i | input | 4 | Opcode from the instruction register |
| ctrl_o | output | 8 | Control-signal field of the current microinstruction |
| car_o | output | 6 | Control address register |

## Verification
The bench checks `car_o` and `ctrl_o` one cycle after each choice of flags and opcode. A wrong select code, a wrong flag tap or a wrong opcode shift therefore shows on the ports at the very next rising edge. Because the next address comes from the current one, a single bad step also sends every later address off the expected path. A stale or misaligned control store appears at the same time as a mismatch between `ctrl_o` and `car_o`. Forced resets in the middle of a run confirm that the CAR returns to 0 at once, without waiting for a clock edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_OPC = 2'd2
  } addr_sel_e;

  localparam int unsigned BC_W        = 3;
  localparam logic [2:0]  BC_ALWAYS_A = 3'd0;
  localparam logic [2:0]  BC_ALWAYS_B = 3'd1;
  localparam logic [2:0]  BC_COND     = 3'd2;
  localparam logic [2:0]  BC_MAP      = 3'd3;
  localparam int unsigned MAP_SHIFT   = 2;
endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned FSEL_W = 2,
  localparam int unsigned BC_W   = useq_pkg::BC_W,
  localparam int unsigned WORD_W = CTRL_W + BC_W + FSEL_W + 2 * ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // program formula: ctrl | bc | fsel | field_a | field_b
  function automatic logic [WORD_W-1:0] build(input int unsigned n);
    logic [ADDR_W-1:0] a;
    logic [CTRL_W-1:0] ctrl;
    logic [BC_W-1:0]   bc;
    logic [FSEL_W-1:0] fsel;
    logic [ADDR_W-1:0] fa;
    logic [ADDR_W-1:0] fb;
    a    = ADDR_W'(n);
    ctrl = CTRL_W'(a) | (CTRL_W'(1) << (CTRL_W - 1));
    bc   = BC_W'(a) + BC_W'(a >> 3);
    fsel = FSEL_W'(a >> (ADDR_W - FSEL_W));
    fa   = ADDR_W'(n + 3);
    fb   = ADDR_W'(n * 5 + 3);
    return {ctrl, bc, fsel, fa, fb};
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = build(i);
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_branch_logic.sv
module useq_branch_logic #(
  parameter int unsigned FSEL_W = 2,
  localparam int unsigned FLAG_N = 1 << FSEL_W,
  localparam int unsigned BC_W   = useq_pkg::BC_W
) (
  input  logic [BC_W-1:0]    bc_i,
  input  logic [FSEL_W-1:0]  fsel_i,
  input  logic [FLAG_N-1:0]  flags_i,
  output useq_pkg::addr_sel_e sel_o
);
  import useq_pkg::*;

  logic flag_hit;
  assign flag_hit = flags_i[fsel_i];

  always_comb begin
    unique case (bc_i)
      BC_ALWAYS_A: sel_o = SEL_A;
      BC_ALWAYS_B: sel_o = SEL_B;
      BC_COND:     sel_o = flag_hit ? SEL_A : SEL_B;
      BC_MAP:      sel_o = SEL_OPC;
      default:     sel_o = SEL_A; // reserved codes
    endcase
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned OPC_W  = 4
) (
  input  useq_pkg::addr_sel_e sel_i,
  input  logic [ADDR_W-1:0]   field_a_i,
  input  logic [ADDR_W-1:0]   field_b_i,
  input  logic [OPC_W-1:0]    opcode_i,
  output logic [ADDR_W-1:0]   next_o
);
  import useq_pkg::*;

  logic [ADDR_W-1:0] map_addr;
  assign map_addr = ADDR_W'(opcode_i) << MAP_SHIFT;

  always_comb begin
    unique case (sel_i)
      SEL_B:   next_o = field_b_i;
      SEL_OPC: next_o = map_addr;
      default: next_o = field_a_i;
    endcase
  end
endmodule

// File: rtl/dual_addr_useq.sv
module dual_addr_useq #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned OPC_W  = 4,
  parameter int unsigned FSEL_W = 2,
  localparam int unsigned FLAG_N = 1 << FSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] car_o
);
  import useq_pkg::*;

  localparam int unsigned WORD_W = CTRL_W + BC_W + FSEL_W + 2 * ADDR_W;

  logic [ADDR_W-1:0] car_q, car_d;
  logic [WORD_W-1:0] word;
  logic [BC_W-1:0]   bc_w;
  logic [FSEL_W-1:0] fsel_w;
  logic [ADDR_W-1:0] fa_w, fb_w;
  addr_sel_e         sel_w;

  useq_ctrl_store #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .FSEL_W(FSEL_W)
  ) store_i (
    .addr_i(car_q),
    .word_o(word)
  );

  assign {ctrl_o, bc_w, fsel_w, fa_w, fb_w} = word;

  useq_branch_logic #(.FSEL_W(FSEL_W)) branch_i (
    .bc_i   (bc_w),
    .fsel_i (fsel_w),
    .flags_i(flags_i),
    .sel_o  (sel_w)
  );

  useq_addr_mux #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) mux_i (
    .sel_i    (sel_w),
    .field_a_i(fa_w),
    .field_b_i(fb_w),
    .opcode_i (opcode_i),
    .next_o   (car_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) car_q <= '0;
    else         car_q <= car_d;
  end

  assign car_o = car_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned OPC_W  = 4,
  parameter int unsigned FSEL_W = 2,
  localparam int unsigned FLAG_N = 1 << FSEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_N-1:0] flags_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [ADDR_W-1:0] car_o,
  input logic [2:0]        bc,
  input logic [FSEL_W-1:0] fsel,
  input logic [ADDR_W-1:0] fa,
  input logic [ADDR_W-1:0] fb
);
  logic              tap;
  logic [ADDR_W-1:0] map;
  assign tap = flags_i[fsel];
  assign map = ADDR_W'(opcode_i) << 2;

  p_reset_car_r1: assert property (@(posedge clk_i) !rst_ni |-> car_o == '0);

  p_ctrl_field_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[CTRL_W-1] && ctrl_o[ADDR_W-1:0] == car_o);

  p_field_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc == 3'd0 |=> car_o == $past(fa));

  p_field_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc == 3'd1 |=> car_o == $past(fb));

  p_cond_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc == 3'd2 && tap) |=> car_o == $past(fa));

  p_cond_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc == 3'd2 && !tap) |=> car_o == $past(fb));

  p_opc_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc == 3'd3 |=> car_o == $past(map));

  p_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc[2] |=> car_o == $past(fa));
endmodule

bind dual_addr_useq useq_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OPC_W(OPC_W), .FSEL_W(FSEL_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .flags_i (flags_i),
  .opcode_i(opcode_i),
  .ctrl_o  (ctrl_o),
  .car_o   (car_o),
  .bc      (bc_w),
  .fsel    (fsel_w),
  .fa      (fa_w),
  .fb      (fb_w)
);

// File: tb/dual_addr_useq_tb_top.sv
`timescale 1ns/1ps
module dual_addr_useq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] flags_i = '0;
  logic [3:0] opcode_i = '0;
  logic [7:0] ctrl_o;
  logic [5:0] car_o;

  int total = 0;
  int bad = 0;
  int code_seen [8];
  bit done = 1'b0;

  typedef struct {
    logic [5:0] car;
    string      tag;
  } exp_t;
  exp_t q [$];

  always #2 clk_i = ~clk_i;

  dual_addr_useq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flags_i(flags_i),
    .opcode_i(opcode_i), .ctrl_o(ctrl_o), .car_o(car_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // spec model of the program (R2) and selection (R3..R7)
  function automatic logic [2:0] m_bc(input logic [5:0] n);
    return n[2:0] + n[5:3];
  endfunction

  function automatic logic [5:0] m_next(input logic [5:0] n, input logic [3:0] f,
                                        input logic [3:0] op);
    logic [5:0] fa, fb;
    fa = n + 6'd3;
    fb = 6'((n * 5) + 3);
    case (m_bc(n))
      3'd1: return fb;
      3'd2: return f[n[5:4]] ? fa : fb;
      3'd3: return {op, 2'b00};
      default: return fa;
    endcase
  endfunction

  function automatic string m_tag(input logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [5:0] model_car = '0;

  // driver: called just after a falling edge
  task automatic drive(input logic [3:0] f, input logic [3:0] op);
    exp_t e;
    flags_i  = f;
    opcode_i = op;
    code_seen[m_bc(model_car)]++;
    e.car = m_next(model_car, f, op);
    e.tag = m_tag(m_bc(model_car));
    q.push_back(e);
    model_car = e.car;
  endtask

  // monitor: compares one ns after each rising edge
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, 32'(car_o), 32'(e.car));
      check("R2", 32'(ctrl_o), 32'(8'h80 | {2'b00, car_o}));
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1", 32'(car_o), 32'd0);
    check("R1", 32'(ctrl_o), 32'h80);
    model_car = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset held over several edges
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", 32'(car_o), 32'd0);
    check("R1", 32'(ctrl_o), 32'h80);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: release does not move the CAR before a rising edge
    #0.5 check("R8", 32'(car_o), 32'd0);
    // R8: code 0 at address 0, first edge loads 3
    drive(4'hF, 4'h9);
    @(posedge clk_i);
    #1.5 check("R8", 32'(car_o), 32'd3);
    // R6: address 3 maps opcode 9 -> 36
    @(negedge clk_i);
    drive(4'h0, 4'h9);
    @(posedge clk_i);
    #1.5 check("R6", 32'(car_o), 32'd36);

    // random walk over flags and opcodes
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      drive(4'($urandom), 4'($urandom));
      if (i % 700 == 699) begin
        @(posedge clk_i);
        #2;
        do_reset();
        drive(4'($urandom), 4'($urandom));
      end
    end
    @(posedge clk_i);
    #2;

    // every branch code reached at least once
    check("R3", 32'(code_seen[0] > 0), 32'd1);
    check("R4", 32'(code_seen[1] > 0), 32'd1);
    check("R5", 32'(code_seen[2] > 0), 32'd1);
    check("R6", 32'(code_seen[3] > 0), 32'd1);
    check("R7", 32'(code_seen[4] + code_seen[5] + code_seen[6] + code_seen[7] > 0), 32'd1);
    check("R8", 32'(q.size()), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule